// File: doc/BRIEF.md
# Bridge Control Register File

This block holds the control words of a host bridge: power-on and general configuration, address-window mapping, GPIO, interrupt routing, mailboxes, cache and timing settings. It presents them as a bank of 32-bit words on a single-request register port. A request is one cycle of `req_valid` carrying a byte address, a write flag, a full-word flag and write data. Reads answer one cycle later on `rd_data` with `rd_valid`. The bank decodes the word and does nothing else: the DMA, cache and memory-controller logic that uses these words sits elsewhere.

Two words get special treatment. The interrupt-enable word cannot be written directly. Software sets bits by writing a mask to one alias word and clears bits by writing a mask to another. Each alias also keeps the last mask written to it. The interrupt-status word is read-only and shows the pending-interrupt input. In the general-configuration word, a write that takes the soft-reset bit from 0 to 1 stores the new value and also raises a one-cycle reset request to the system.

Top module: `bridge_ctl_regs`

## Requirements
- R1: After reset, the words read back as follows: 0x00 = 0x00000C40, 0x04 = 0x00001384, 0x08 = 0x2BFF8010, 0x0C = 0x255E0091, 0x10 = 0x00006140, 0x1C = 0x000001FF, 0x20 = 0x000001FF, 0x68 = 0x00000008, 0x6C = 0x10000000. Every other storage word reads 0. `soft_rst_req` and `rd_valid` are low.
- R2: There are 28 words at byte offsets 0x00 to 0x6C, with word index = offset >> 2. A full-word write to any word other than 0x38 and 0x3C replaces its content, and a later read returns that value.
- R3: A write of mask M to 0x30 stores M at 0x30 and sets the bits of M in the enable word at 0x38. Other enable bits are left unchanged.
- R4: A write of mask M to 0x34 stores M at 0x34 and clears the bits of M in the enable word at 0x38. Other enable bits are left unchanged.
- R5: Writes to 0x38 and 0x3C change nothing. A read of 0x3C returns the value of `irq_status` at the request cycle. The enable word resets to 0.
- R6: A full-word write to 0x04 whose data bit 2 is 1, while the stored bit 2 is 0, drives `soft_rst_req` high for exactly the one cycle after the write. The value is still stored. Any other write gives no pulse.
- R7: A write to an offset of 0x70 or above changes no word. A read of such an offset returns 0.
- R8: A request with `req_full` = 0, or with `req_addr[1:0]` not 0, is not a valid access. As a write it changes nothing and gives no pulse. As a read it returns 0.
- R9: `rd_valid` is high in the cycle after a read request and low after any other cycle. `rd_data` holds the read result in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_full | input | 1 | 1 = full 32-bit access |
| req_addr | input | ADDR_W (8) | Byte offset |
| req_wdata | input | DATA_W (32) | Write data |
| irq_status | input | DATA_W (32) | Pending interrupts shown at 0x3C |
| rd_valid | output | 1 | Read answer strobe |
| rd_data | output | DATA_W (32) | Read answer |
| soft_rst_req | output | 1 | One-cycle system reset request |

## Verification
Every mapped offset is written with two unrelated data patterns and then read back in full. This separates correct word decode from aliasing between neighbouring words, and shows that the two read-only words ignore the data. Walking-one and overlapping masks on the set and clear aliases tell OR and AND-NOT merging apart from plain storage. A sequence of general-configuration writes (1 to 1, 1 to 0, 0 to 1, 1 to 1) separates edge detection from level detection. Sweeps over all unmapped offsets, partial-width accesses and misaligned accesses are each followed by a full readback, which confirms that no word was touched.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

  localparam int IDX_GENCFG = 1;
  localparam int IDX_ENSET  = 12;
  localparam int IDX_ENCLR  = 13;
  localparam int IDX_EN     = 14;
  localparam int IDX_STAT   = 15;
  localparam int SOFT_BIT   = 2;

  typedef enum logic [2:0] {
    K_PLAIN, K_GENCFG, K_ENSET, K_ENCLR, K_ROEN, K_ROSTAT
  } reg_kind_e;

  function automatic reg_kind_e kind_of(input int idx);
    case (idx)
      IDX_GENCFG: return K_GENCFG;
      IDX_ENSET:  return K_ENSET;
      IDX_ENCLR:  return K_ENCLR;
      IDX_EN:     return K_ROEN;
      IDX_STAT:   return K_ROSTAT;
      default:    return K_PLAIN;
    endcase
  endfunction

  function automatic logic [31:0] reset_value(input int idx);
    case (idx)
      0:  return 32'h0000_0C40;
      1:  return 32'h0000_1384;
      2:  return 32'h2BFF_8010;
      3:  return 32'h255E_0091;
      4:  return 32'h0000_6140;
      7:  return 32'h0000_01FF;
      8:  return 32'h0000_01FF;
      26: return 32'h0000_0008;
      27: return 32'h1000_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] enable_next(input logic [31:0] cur,
                                              input logic set_op,
                                              input logic clr_op,
                                              input logic [31:0] mask);
    logic [31:0] v;
    v = cur;
    if (set_op) v = v | mask;
    if (clr_op) v = v & ~mask;
    return v;
  endfunction

  function automatic logic rising_bit(input logic old_b, input logic new_b);
    return !old_b && new_b;
  endfunction

endpackage

// File: rtl/bcr_decode.sv
module bcr_decode #(
  parameter int ADDR_W = 8,
  parameter int NREG   = 28,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_full,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [IDX_W-1:0]  idx,
  output logic              wr_hit,
  output logic              rd_hit,
  output bcr_pkg::reg_kind_e kind
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] LIMIT = WORD_W'(NREG);

  logic [WORD_W-1:0] word;
  logic              legal;

  assign word   = req_addr[ADDR_W-1:2];
  assign idx    = IDX_W'(word);
  assign legal  = req_full && (req_addr[1:0] == 2'b00) && (word < LIMIT);
  assign wr_hit = req_valid && req_write && legal;
  assign rd_hit = req_valid && !req_write && legal;
  assign kind   = bcr_pkg::kind_of(int'(idx));
endmodule

// File: rtl/bcr_regbank.sv
module bcr_regbank #(
  parameter int DATA_W = 32,
  parameter int NREG   = 28,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [NREG-1:0][DATA_W-1:0]  q
);
  import bcr_pkg::*;

  for (genvar i = 0; i < NREG; i++) begin : g_word
    if (kind_of(i) == K_ROEN || kind_of(i) == K_ROSTAT) begin : g_ro
      assign q[i] = '0;
    end else begin : g_rw
      logic [DATA_W-1:0] r;
      always_ff @(posedge clk) begin
        if (!rst_n)
          r <= DATA_W'(reset_value(i));
        else if (wr_en && (wr_idx == IDX_W'(i)))
          r <= wr_data;
      end
      assign q[i] = r;
    end
  end
endmodule

// File: rtl/bcr_int_enable.sv
module bcr_int_enable #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_op,
  input  logic              clr_op,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] en
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      en <= '0;
    else if (set_op || clr_op)
      en <= DATA_W'(bcr_pkg::enable_next(32'(en), set_op, clr_op, 32'(mask)));
  end
endmodule

// File: rtl/bcr_softreset.sv
module bcr_softreset #(
  parameter int DATA_W = 32,
  parameter int BIT    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_write,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] new_val,
  output logic              edge_seen,
  output logic              pulse
);
  assign edge_seen = gen_write && bcr_pkg::rising_bit(old_val[BIT], new_val[BIT]);

  always_ff @(posedge clk) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= edge_seen;
  end
endmodule

// File: rtl/bridge_ctl_regs.sv
module bridge_ctl_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NREG   = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_full,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] irq_status,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              soft_rst_req
);
  import bcr_pkg::*;
  localparam int IDX_W = $clog2(NREG);

  logic [IDX_W-1:0]            idx;
  logic                        wr_hit, rd_hit;
  reg_kind_e                   kind;
  logic [NREG-1:0][DATA_W-1:0] bank;
  logic [DATA_W-1:0]           en_value;
  logic                        set_hit, clr_hit, gen_hit, soft_edge;
  logic                        store_en;
  logic [DATA_W-1:0]           rd_mux;

  bcr_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_full(req_full),
    .req_addr(req_addr), .idx(idx), .wr_hit(wr_hit), .rd_hit(rd_hit),
    .kind(kind)
  );

  assign set_hit  = wr_hit && (kind == K_ENSET);
  assign clr_hit  = wr_hit && (kind == K_ENCLR);
  assign gen_hit  = wr_hit && (kind == K_GENCFG);
  assign store_en = wr_hit && (kind != K_ROEN) && (kind != K_ROSTAT);

  bcr_regbank #(.DATA_W(DATA_W), .NREG(NREG)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(store_en), .wr_idx(idx),
    .wr_data(req_wdata), .q(bank)
  );

  bcr_int_enable #(.DATA_W(DATA_W)) u_en (
    .clk(clk), .rst_n(rst_n), .set_op(set_hit), .clr_op(clr_hit),
    .mask(req_wdata), .en(en_value)
  );

  bcr_softreset #(.DATA_W(DATA_W), .BIT(SOFT_BIT)) u_soft (
    .clk(clk), .rst_n(rst_n), .gen_write(gen_hit),
    .old_val(bank[IDX_GENCFG]), .new_val(req_wdata),
    .edge_seen(soft_edge), .pulse(soft_rst_req)
  );

  always_comb begin
    case (kind)
      K_ROEN:   rd_mux = en_value;
      K_ROSTAT: rd_mux = irq_status;
      default:  rd_mux = bank[idx];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= req_valid && !req_write;
      if (req_valid && !req_write)
        rd_data <= rd_hit ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/bridge_ctl_regs_checker.sv
module bridge_ctl_regs_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_full,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              soft_rst_req,
  input logic [DATA_W-1:0] en_value,
  input logic              set_hit,
  input logic              clr_hit,
  input logic              rd_hit
);
  p_rd_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid);
  p_rd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rd_valid);
  p_set_merge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> ((en_value & $past(req_wdata)) == $past(req_wdata)));
  p_clr_merge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> ((en_value & $past(req_wdata)) == '0));
  p_en_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_hit || clr_hit) |=> $stable(en_value));
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_req |=> !soft_rst_req);
  p_pulse_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst_req && !(req_valid && req_write && req_full && req_addr == ADDR_W'(4)))
      |=> !soft_rst_req);
  p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !rd_hit) |=> (rd_data == '0));
  p_partial_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && (!req_full || req_addr[1:0] != 2'b00)) |=> (rd_data == '0));
endmodule

bind bridge_ctl_regs bridge_ctl_regs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_full(req_full), .req_addr(req_addr), .req_wdata(req_wdata),
  .rd_valid(rd_valid), .rd_data(rd_data), .soft_rst_req(soft_rst_req),
  .en_value(en_value), .set_hit(set_hit), .clr_hit(clr_hit), .rd_hit(rd_hit)
);

// File: tb/bridge_ctl_regs_test.sv
module bridge_ctl_regs_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_write = 0, req_full = 1;
  logic [7:0]  req_addr = 0;
  logic [31:0] req_wdata = 0, irq_status = 0;
  logic        rd_valid, soft_rst_req;
  logic [31:0] rd_data;

  int checks = 0, fails = 0;
  logic [31:0] exp_w [28];

  always #5 clk = ~clk;

  bridge_ctl_regs uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_full(req_full), .req_addr(req_addr), .req_wdata(req_wdata),
    .irq_status(irq_status), .rd_valid(rd_valid), .rd_data(rd_data),
    .soft_rst_req(soft_rst_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] pat(input int i, input int k);
    return {8'(i), 8'(k * 3 + 1), ~8'(i), 8'(i * 7 + k)};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 28; i++) exp_w[i] = 32'h0;
    exp_w[0] = 32'hC40; exp_w[1] = 32'h1384; exp_w[2] = 32'h2BFF8010;
    exp_w[3] = 32'h255E0091; exp_w[4] = 32'h6140; exp_w[7] = 32'h1FF;
    exp_w[8] = 32'h1FF; exp_w[26] = 32'h8; exp_w[27] = 32'h10000000;
  endtask

  // write, then check the soft reset pulse (R6) and the read strobe (R9)
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic full);
    logic legal, pulse_exp;
    int   i;
    i = int'(a[7:2]);
    legal = full && a[1:0] == 2'b00 && i < 28;
    pulse_exp = legal && i == 1 && !exp_w[1][2] && d[2];
    if (legal) begin
      if (i == 12) begin exp_w[12] = d; exp_w[14] = exp_w[14] | d; end
      else if (i == 13) begin exp_w[13] = d; exp_w[14] = exp_w[14] & ~d; end
      else if (i != 14 && i != 15) exp_w[i] = d;
    end
    @(negedge clk);
    req_valid = 1; req_write = 1; req_full = full; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_full = 1;
    check("R6 pulse after write", {31'b0, soft_rst_req}, {31'b0, pulse_exp});
    check("R9 no strobe after write", {31'b0, rd_valid}, 32'h0);
    @(negedge clk);
    check("R6 pulse one cycle", {31'b0, soft_rst_req}, 32'h0);
  endtask

  task automatic rd(input logic [7:0] a, input logic full, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_full = full; req_addr = a;
    @(negedge clk);
    req_valid = 0; req_full = 1;
    check("R9 read strobe", {31'b0, rd_valid}, 32'h1);
    d = rd_data;
  endtask

  task automatic read_all(input string req);
    logic [31:0] d;
    for (int i = 0; i < 28; i++) begin
      rd(8'(i * 4), 1'b1, d);
      check(req, d, (i == 15) ? irq_status : exp_w[i]);
    end
  endtask

  initial begin
    #2000000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    model_reset();
    irq_status = 32'hDEAD_0001;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset rd_valid", {31'b0, rd_valid}, 32'h0);
    check("R1 reset soft_rst_req", {31'b0, soft_rst_req}, 32'h0);
    read_all("R1 reset value");

    // R2 two full sweeps with unrelated patterns, including the read-only words (R5)
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < 28; i++) wr(8'(i * 4), (k == 0) ? pat(i, k) : ~pat(i, k), 1'b1);
      irq_status = pat(99, k);
      read_all("R2 sweep readback");
    end

    // R3 / R4 walking ones through the aliases
    wr(8'h34, 32'hFFFF_FFFF, 1'b1);
    for (int b = 0; b < 32; b++) begin
      wr(8'h30, 32'h1 << b, 1'b1);
      rd(8'h38, 1'b1, d);
      check("R3 set accumulates", d, exp_w[14]);
    end
    rd(8'h30, 1'b1, d);
    check("R3 set alias stores mask", d, 32'h8000_0000);
    for (int b = 0; b < 32; b += 3) begin
      wr(8'h34, 32'h1 << b, 1'b1);
      rd(8'h38, 1'b1, d);
      check("R4 clear removes bits", d, exp_w[14]);
    end
    wr(8'h34, 32'h0F0F_0F0F, 1'b1);
    wr(8'h30, 32'h00FF_00FF, 1'b1);
    rd(8'h38, 1'b1, d);
    check("R4 overlap set after clear", d, exp_w[14]);
    rd(8'h34, 1'b1, d);
    check("R4 clear alias stores mask", d, 32'h0F0F_0F0F);

    // R5 direct writes to enable/status
    wr(8'h38, 32'h1234_5678, 1'b1);
    wr(8'h3C, 32'h8765_4321, 1'b1);
    irq_status = 32'hA5A5_5A5A;
    rd(8'h38, 1'b1, d);
    check("R5 enable ignores direct write", d, exp_w[14]);
    rd(8'h3C, 1'b1, d);
    check("R5 status follows input", d, 32'hA5A5_5A5A);

    // R6 edge sequence on general configuration bit 2
    wr(8'h04, 32'h4, 1'b1);
    wr(8'h04, 32'h4, 1'b1);
    wr(8'h04, 32'h0, 1'b1);
    wr(8'h04, 32'hFFFF_FFFF, 1'b1);
    rd(8'h04, 1'b1, d);
    check("R6 value stored", d, 32'hFFFF_FFFF);
    wr(8'h04, 32'h0000_0004, 1'b1);
    wr(8'h04, 32'h0000_0000, 1'b1);
    wr(8'h04, 32'h0000_0004, 1'b0);
    wr(8'h05, 32'h0000_0004, 1'b1);

    // R7 unmapped offsets
    for (int a = 8'h70; a < 256; a += 4) wr(8'(a), 32'hFFFF_FFFF, 1'b1);
    for (int a = 8'h70; a < 256; a += 12) begin
      rd(8'(a), 1'b1, d);
      check("R7 unmapped read zero", d, 32'h0);
    end
    read_all("R7 no word changed");

    // R8 partial and misaligned accesses
    for (int i = 0; i < 28; i++) begin
      wr(8'(i * 4), 32'h5555_AAAA, 1'b0);
      wr(8'(i * 4 + 2), 32'hAAAA_5555, 1'b1);
    end
    read_all("R8 no word changed");
    rd(8'h00, 1'b0, d);
    check("R8 partial read zero", d, 32'h0);
    rd(8'h09, 1'b1, d);
    check("R8 misaligned read zero", d, 32'h0);

    @(negedge clk);
    check("R9 idle no strobe", {31'b0, rd_valid}, 32'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule